// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block gathers eight interrupt request lines into a single request toward a processor. Each rising edge on a request line is latched in a pending register. Lines can be blocked by a mask register. Lines that have been acknowledged are tracked in an in-service register until software retires them. Priority is not fixed: a three-bit rotation offset names the line that currently ranks highest, and the rank falls as the scan moves upward from that line, wrapping modulo eight. The processor is interrupted only when the best unmasked pending line strictly outranks the best line already in service.

Software reaches the block through a byte-wide port with one address bit. A write to address 0 with bit 4 set starts a short sequence of setup words that arrive at address 1: the vector base, an optional link word and an optional mode word. Once setup is complete, address 1 holds the mask register and address 0 takes commands. The commands retire in-service lines, move the rotation offset, change the read selection, arm a poll, and switch the special-mask mode on or off. An acknowledge strobe moves the winning line from pending to in service. If automatic end-of-interrupt is on, the line is not marked in service and the offset may rotate instead. The interrupt output and the winning line index are registered.

Top module: `irqc_core`

## Requirements
- R1: After reset, `irq_o` is 0, `line_o` is 0 and `vbase_o` is 0. The pending, mask and in-service registers, the rotation offset and all mode flags are 0, and the block is in the normal (non-setup) state.
- R2: The rank of line k is (k - offset) mod 8, and rank 0 is best. The winner is the unmasked pending line with the best rank. It is serviceable only if its rank is strictly better than the best rank in the counted in-service set. An empty in-service set counts as rank 8.
- R3: A write to address 0 with bit 4 set clears the pending, mask and in-service registers, the offset, the vector base, and the poll, read-select, special-mask, auto-EOI, rotate-on-auto-EOI and nested flags. It latches a four-word flag from bit 0 and a single flag from bit 1. The next write to address 1 stores the vector base as the data AND 0xF8, and `vbase_o` shows it.
- R4: After the base word, the single flag selects the next step. If it is set, the block goes to the mode word when the four-word flag is set, and otherwise returns to normal. If it is clear, the block takes one link word (which has no effect), then goes to the mode word when the four-word flag is set, and otherwise returns to normal. In the mode word, bit 4 sets nested mode and bit 1 sets auto-EOI.
- R5: In the normal state, a write to address 1 loads the mask register. A line whose mask bit is 1 never wins.
- R6: A write to address 0 with bit 3 set and bit 4 clear is an operation command. Bit 2 arms a poll. If bit 1 is set, read-select takes the value of bit 0. If bit 6 is set, special mask takes the value of bit 5. While special mask is on, in-service lines that are masked are left out of the counted in-service set.
- R7: Any other write to address 0 decodes bits 7:5 as a command:
  - Code 1 clears the best-ranked in-service bit.
  - Code 5 does the same and then sets the offset to that line + 1.
  - Code 3 clears the in-service bit named by bits 2:0.
  - Code 7 clears that bit and sets the offset to the named line + 1.
  - Code 6 sets the offset to bits 2:0 + 1.
  - Codes 0 and 4 load rotate-on-auto-EOI from bit 7.
  - Code 2 changes nothing.
- R8: An acknowledge while a serviceable winner exists clears the winner's pending bit. With auto-EOI off, it sets the winner's in-service bit. With auto-EOI on, the in-service register is unchanged, and if rotate-on-auto-EOI is set the offset becomes the winner + 1.
- R9: While a poll is armed, a read returns the serviceable winner, or 7 if there is none. The read clears that line's pending and in-service bits and disarms the poll. The next read is an ordinary one.
- R10: Ordinary reads return the mask register at address 1. At address 0 they return the in-service register when read-select is 1 and the pending register when it is 0.
- R11: With nested mode on (this instance is the primary one), in-service bit 2 is left out of the counted in-service set. A new request on line 2 can therefore be serviced while line 2 is in service.
- R12: A rising edge on `req_i[k]` sets pending bit k. A line that is held high does not set the bit again.
- R13: `irq_o` and `line_o` are registered. They show the serviceable winner computed from the register state of the previous cycle. `line_o` is 0 when there is no serviceable winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request lines, rising-edge sensitive |
| addr_i | input | 1 | Register address bit |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current address and state |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| line_o | output | 3 | Index of the serviceable winning line |
| vbase_o | output | 8 | Stored vector base |

## Verification
The bench builds the block with its default parameters: eight lines, the primary-instance variant and line 2 as the link line. With only eight lines and eight offsets, it can sweep every request pattern against every rotation offset. It compares the winner with an arithmetic rank computation for each of the 2048 pairs. Directed sequences then cover the strict-outrank rule, every command code, the auto-EOI and rotation paths, special mask, nested mode and each setup-word path.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Setup-word sequencer states; the zero value is the normal state.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_BASE  = 2'd1,
        SEQ_LINK  = 2'd2,
        SEQ_EXTRA = 2'd3
    } seq_e;

    // Command codes carried in bits 7:5 of a plain address-0 write.
    typedef enum logic [2:0] {
        OP_AEOI_ROT_A = 3'd0,
        OP_EOI_TOP    = 3'd1,
        OP_NONE       = 3'd2,
        OP_EOI_LINE   = 3'd3,
        OP_AEOI_ROT_B = 3'd4,
        OP_EOI_TOP_RT = 3'd5,
        OP_SET_OFFSET = 3'd6,
        OP_EOI_LINE_R = 3'd7
    } op_e;

endpackage

// File: rtl/irqc_prio_scan.sv
// Rotated rank finder: returns the distance, counted upward from base_i
// with wraparound, to the first set bit of set_i; LINES when set_i is empty.
module irqc_prio_scan #(
    parameter int unsigned LINES = 8,
    localparam int unsigned IW = $clog2(LINES)
) (
    input  logic [LINES-1:0] set_i,
    input  logic [IW-1:0]    base_i,
    output logic [IW:0]      rank_o
);

    logic [IW-1:0] idx;

    always_comb begin
        rank_o = (IW+1)'(LINES);
        idx    = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            idx = base_i + IW'(k);
            if (set_i[idx]) begin
                rank_o = (IW+1)'(k);
            end
        end
    end

endmodule

// File: rtl/irqc_arbiter.sv
// Picks the best unmasked pending line and decides whether it strictly
// outranks the counted in-service set.
module irqc_arbiter #(
    parameter int unsigned LINES     = 8,
    parameter bit          PRIMARY   = 1'b1,
    parameter int unsigned LINK_LINE = 2,
    localparam int unsigned IW = $clog2(LINES)
) (
    input  logic [LINES-1:0] irr_i,
    input  logic [LINES-1:0] imr_i,
    input  logic [LINES-1:0] isr_i,
    input  logic [IW-1:0]    offset_i,
    input  logic             smask_i,
    input  logic             nested_i,
    output logic             win_valid_o,
    output logic [IW-1:0]    win_line_o
);

    logic [LINES-1:0] pend;
    logic [LINES-1:0] svc;
    logic [LINES-1:0] nest_keep;
    logic [IW:0]      pend_rank;
    logic [IW:0]      svc_rank;

    generate
        if (PRIMARY) begin : g_nest
            assign nest_keep = nested_i ? ~(LINES'(1) << LINK_LINE) : '1;
        end else begin : g_no_nest
            assign nest_keep = '1;
        end
    endgenerate

    assign pend = irr_i & ~imr_i;
    assign svc  = (smask_i ? (isr_i & ~imr_i) : isr_i) & nest_keep;

    irqc_prio_scan #(.LINES(LINES)) u_pend_scan (
        .set_i  (pend),
        .base_i (offset_i),
        .rank_o (pend_rank)
    );

    irqc_prio_scan #(.LINES(LINES)) u_svc_scan (
        .set_i  (svc),
        .base_i (offset_i),
        .rank_o (svc_rank)
    );

    assign win_valid_o = (pend_rank != (IW+1)'(LINES)) && (pend_rank < svc_rank);
    assign win_line_o  = offset_i + pend_rank[IW-1:0];

endmodule

// File: rtl/irqc_core.sv
// Eight-line interrupt controller with rotating priority and a byte
// register port. Command fields sit at fixed byte positions, so LINES is 8.
module irqc_core
    import irqc_pkg::*;
#(
    parameter int unsigned LINES     = 8,
    parameter bit          PRIMARY   = 1'b1,
    parameter int unsigned LINK_LINE = 2,
    localparam int unsigned IW = $clog2(LINES),
    localparam int unsigned DW = LINES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] req_i,
    input  logic          addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          ack_i,
    output logic          irq_o,
    output logic [IW-1:0] line_o,
    output logic [DW-1:0] vbase_o
);

    localparam logic [DW-1:0] BASE_KEEP = ~DW'((1 << IW) - 1);
    localparam logic [DW-1:0] EMPTY_POLL = DW'(LINES - 1);

    typedef struct packed {
        logic [DW-1:0] irr;
        logic [DW-1:0] imr;
        logic [DW-1:0] isr;
        logic [DW-1:0] last;
        logic [DW-1:0] base;
        logic [IW-1:0] off;
        seq_e          seq;
        logic          four;
        logic          single;
        logic          rsel;
        logic          poll;
        logic          smask;
        logic          aeoi;
        logic          raeoi;
        logic          nested;
        logic          irq;
        logic [IW-1:0] line;
    } state_t;

    state_t st_q;
    state_t st_d;

    logic          win_valid;
    logic [IW-1:0] win_line;
    logic [IW:0]   top_rank;
    logic [IW-1:0] top_line;
    logic          top_found;
    logic [IW-1:0] cmd_line;
    op_e           cmd_op;

    irqc_arbiter #(
        .LINES     (LINES),
        .PRIMARY   (PRIMARY),
        .LINK_LINE (LINK_LINE)
    ) u_arb (
        .irr_i       (st_q.irr),
        .imr_i       (st_q.imr),
        .isr_i       (st_q.isr),
        .offset_i    (st_q.off),
        .smask_i     (st_q.smask),
        .nested_i    (st_q.nested),
        .win_valid_o (win_valid),
        .win_line_o  (win_line)
    );

    // Best-ranked bit of the raw in-service register, target of the
    // non-specific retire commands.
    irqc_prio_scan #(.LINES(LINES)) u_top_scan (
        .set_i  (st_q.isr),
        .base_i (st_q.off),
        .rank_o (top_rank)
    );

    assign top_found = (top_rank != (IW+1)'(LINES));
    assign top_line  = st_q.off + top_rank[IW-1:0];
    assign cmd_line  = wdata_i[IW-1:0];
    assign cmd_op    = op_e'(wdata_i[7:5]);

    always_comb begin
        st_d = st_q;

        // Edge capture on the request lines.
        st_d.last = req_i;
        st_d.irr  = st_q.irr | (req_i & ~st_q.last);

        // Acknowledge of the serviceable winner.
        if (ack_i && win_valid) begin
            if (st_q.aeoi) begin
                if (st_q.raeoi) begin
                    st_d.off = win_line + IW'(1);
                end
            end else begin
                st_d.isr[win_line] = 1'b1;
            end
            st_d.irr[win_line] = 1'b0;
        end

        // Poll read consumes the winner.
        if (rd_i && st_q.poll) begin
            if (win_valid) begin
                st_d.irr[win_line] = 1'b0;
                st_d.isr[win_line] = 1'b0;
            end
            st_d.poll = 1'b0;
        end

        if (wr_i) begin
            if (!addr_i) begin
                if (wdata_i[4]) begin
                    st_d.irr    = '0;
                    st_d.imr    = '0;
                    st_d.isr    = '0;
                    st_d.base   = '0;
                    st_d.off    = '0;
                    st_d.rsel   = 1'b0;
                    st_d.poll   = 1'b0;
                    st_d.smask  = 1'b0;
                    st_d.aeoi   = 1'b0;
                    st_d.raeoi  = 1'b0;
                    st_d.nested = 1'b0;
                    st_d.four   = wdata_i[0];
                    st_d.single = wdata_i[1];
                    st_d.seq    = SEQ_BASE;
                end else if (wdata_i[3]) begin
                    if (wdata_i[2]) begin
                        st_d.poll = 1'b1;
                    end
                    if (wdata_i[1]) begin
                        st_d.rsel = wdata_i[0];
                    end
                    if (wdata_i[6]) begin
                        st_d.smask = wdata_i[5];
                    end
                end else begin
                    unique case (cmd_op)
                        OP_AEOI_ROT_A, OP_AEOI_ROT_B: begin
                            st_d.raeoi = wdata_i[7];
                        end
                        OP_EOI_TOP, OP_EOI_TOP_RT: begin
                            if (top_found) begin
                                st_d.isr[top_line] = 1'b0;
                                if (cmd_op == OP_EOI_TOP_RT) begin
                                    st_d.off = top_line + IW'(1);
                                end
                            end
                        end
                        OP_EOI_LINE: begin
                            st_d.isr[cmd_line] = 1'b0;
                        end
                        OP_SET_OFFSET: begin
                            st_d.off = cmd_line + IW'(1);
                        end
                        OP_EOI_LINE_R: begin
                            st_d.isr[cmd_line] = 1'b0;
                            st_d.off = cmd_line + IW'(1);
                        end
                        default: begin
                        end
                    endcase
                end
            end else begin
                unique case (st_q.seq)
                    SEQ_IDLE: begin
                        st_d.imr = wdata_i;
                    end
                    SEQ_BASE: begin
                        st_d.base = wdata_i & BASE_KEEP;
                        if (st_q.single) begin
                            st_d.seq = st_q.four ? SEQ_EXTRA : SEQ_IDLE;
                        end else begin
                            st_d.seq = SEQ_LINK;
                        end
                    end
                    SEQ_LINK: begin
                        st_d.seq = st_q.four ? SEQ_EXTRA : SEQ_IDLE;
                    end
                    SEQ_EXTRA: begin
                        st_d.nested = wdata_i[4];
                        st_d.aeoi   = wdata_i[1];
                        st_d.seq    = SEQ_IDLE;
                    end
                    default: begin
                        st_d.seq = SEQ_IDLE;
                    end
                endcase
            end
        end

        // Registered request output, from this cycle's state.
        st_d.irq  = win_valid;
        st_d.line = win_valid ? win_line : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.poll) begin
            rdata_o = win_valid ? DW'(win_line) : EMPTY_POLL;
        end else if (addr_i) begin
            rdata_o = st_q.imr;
        end else begin
            rdata_o = st_q.rsel ? st_q.isr : st_q.irr;
        end
    end

    assign irq_o   = st_q.irq;
    assign line_o  = st_q.line;
    assign vbase_o = st_q.base;

endmodule

// File: rtl/irqc_core_sva.sv
module irqc_core_sva #(
    parameter int unsigned LINES = 8,
    localparam int unsigned IW = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_i,
    input logic             rd_i,
    input logic             ack_i,
    input logic             addr_i,
    input logic [LINES-1:0] wdata_i,
    input logic             irq_o,
    input logic [IW-1:0]    line_o,
    input logic [LINES-1:0] irr_q,
    input logic [LINES-1:0] imr_q,
    input logic [LINES-1:0] isr_q,
    input logic             poll_q,
    input logic             aeoi_q,
    input logic [1:0]       seq_q,
    input logic             win_valid,
    input logic [IW-1:0]    win_line
);

    logic [LINES-1:0] pend_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_prev <= '0;
        end else begin
            pend_prev <= irr_q & ~imr_q;
        end
    end

    // R2, R5: a raised request names a line that was pending and unmasked.
    assert_irq_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend_prev[line_o]);

    // R3: a setup start clears mask and in-service and enters the base step.
    assert_init_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !addr_i && wdata_i[4]) |=> (seq_q == 2'd1 && imr_q == '0 && isr_q == '0));

    // R5: a normal-state write to address 1 lands in the mask register.
    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i && seq_q == 2'd0) |=> (imr_q == $past(wdata_i)));

    // R8: an acknowledge without auto-EOI marks the winner in service.
    assert_ack_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && win_valid && !aeoi_q && !wr_i && !(rd_i && poll_q))
        |=> isr_q[$past(win_line)]);

    // R9: a poll is consumed by one read.
    assert_poll_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && poll_q && !wr_i) |=> !poll_q);

endmodule

bind irqc_core irqc_core_sva #(.LINES(LINES)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .ack_i     (ack_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .irq_o     (irq_o),
    .line_o    (line_o),
    .irr_q     (st_q.irr),
    .imr_q     (st_q.imr),
    .isr_q     (st_q.isr),
    .poll_q    (st_q.poll),
    .aeoi_q    (st_q.aeoi),
    .seq_q     (st_q.seq),
    .win_valid (win_valid),
    .win_line  (win_line)
);

// File: tb/irqc_core_test.sv
`timescale 1ns/1ps
module irqc_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       addr_i = 1'b0;
    logic       wr_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       ack_i = 1'b0;
    logic       irq_o;
    logic [2:0] line_o;
    logic [7:0] vbase_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irqc_core uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .addr_i  (addr_i),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .ack_i   (ack_i),
        .irq_o   (irq_o),
        .line_o  (line_o),
        .vbase_o (vbase_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // irq and line packed as {irq, line}; 0 when nothing is serviceable.
    task automatic chk_out(input string tag, input int exp_line);
        chk(tag, {irq_o, line_o}, (exp_line < 0) ? 0 : (8 | exp_line));
    endtask

    // First set bit scanning upward from off, modulo 8; -1 if none.
    function automatic int first_from(input int mask, input int off);
        for (int k = 0; k < 8; k++) begin
            if (mask[(off + k) % 8]) return (off + k) % 8;
        end
        return -1;
    endfunction

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr_i = a; rd_i = 1'b1;
        #1 v = rdata_o;
        @(negedge clk);
        rd_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] p);
        @(negedge clk);
        req_i = p;
        @(negedge clk);
        req_i = '0;
        @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic init_std();
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq/line", {irq_o, line_o}, 0);
        chk("R1 vbase", vbase_o, 0);
        addr_i = 1'b1; #1 chk("R1 mask read", rdata_o, 0);
        addr_i = 1'b0; #1 chk("R1 pending read", rdata_o, 0);

        // R2 / R12: every request pattern against every offset
        for (int off = 0; off < 8; off++) begin
            for (int p = 0; p < 256; p++) begin
                init_std();
                if (off != 0) wr(1'b0, 8'hC0 | 8'((off + 7) % 8));
                pulse(8'(p));
                chk_out("R2 rotated winner", first_from(p, off));
                rd(1'b0, v);
                chk("R12 pending capture", v, p);
            end
        end

        // R13: output lags the captured state by one cycle
        init_std();
        @(negedge clk); req_i = 8'h01;
        @(negedge clk); chk("R13 not yet", irq_o, 0);
        req_i = 8'h00;
        @(negedge clk); chk_out("R13 registered", 0);

        // R12: held level does not re-request after ack
        init_std();
        @(negedge clk); req_i = 8'h02;
        @(negedge clk);
        ack();
        wr(1'b0, 8'h20);
        repeat (2) @(negedge clk);
        chk_out("R12 held level", -1);
        req_i = 8'h00;
        @(negedge clk);

        // R2 strict outrank, R8 normal ack
        init_std();
        pulse(8'h08);
        ack();
        chk_out("R8 after ack", -1);
        rd(1'b0, v); chk("R8 pending cleared", v, 0);
        pulse(8'h08);
        chk_out("R2 equal rank blocked", -1);
        pulse(8'h20);
        chk_out("R2 lower rank blocked", -1);
        pulse(8'h02);
        chk_out("R2 higher rank wins", 1);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R10 in-service read", v, 8'h08);
        ack();
        rd(1'b0, v); chk("R8 in-service set", v, 8'h0A);

        // R7 commands
        wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R7 code1 retires top", v, 8'h08);
        chk_out("R7 code1 still blocked", -1);
        wr(1'b0, 8'hA0);
        chk_out("R7 code5 rotates", 5);
        ack();
        wr(1'b0, 8'h40);
        rd(1'b0, v); chk("R7 code2 no effect", v, 8'h20);
        wr(1'b0, 8'h65);
        rd(1'b0, v); chk("R7 code3 specific", v, 8'h00);
        chk_out("R7 after code3", 3);
        ack();
        wr(1'b0, 8'hC0);
        wr(1'b0, 8'hE3);
        rd(1'b0, v); chk("R7 code7 clears", v, 8'h00);
        pulse(8'h11);
        chk_out("R7 code7 offset", 4);

        // R8 auto-EOI and rotation
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h02);
        chk("R3 base stored", vbase_o, 8'h40);
        pulse(8'h04);
        ack();
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R8 aeoi no in-service", v, 0);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); chk("R8 aeoi pending cleared", v, 0);
        wr(1'b0, 8'h80);
        pulse(8'h04);
        ack();
        pulse(8'h09);
        chk_out("R8 rotate on aeoi", 3);
        wr(1'b0, 8'h00);
        ack();
        pulse(8'h10);
        chk_out("R8 no rotate when off", 4);

        // R9 poll
        init_std();
        pulse(8'h24);
        wr(1'b0, 8'h0C);
        rd(1'b0, v); chk("R9 poll winner", v, 2);
        rd(1'b0, v); chk("R9 poll consumed", v, 8'h20);
        wr(1'b0, 8'h0C);
        rd(1'b0, v); chk("R9 poll second", v, 5);
        wr(1'b0, 8'h0C);
        rd(1'b0, v); chk("R9 poll empty", v, 7);

        // R5 mask, R10 reads
        init_std();
        wr(1'b1, 8'h0F);
        rd(1'b1, v); chk("R10 mask read", v, 8'h0F);
        pulse(8'h05);
        chk_out("R5 masked ignored", -1);
        pulse(8'h40);
        chk_out("R5 unmasked wins", 6);
        rd(1'b0, v); chk("R10 pending read", v, 8'h45);

        // R6 special mask
        init_std();
        pulse(8'h02);
        ack();
        wr(1'b1, 8'h02);
        pulse(8'h10);
        chk_out("R6 blocked by service", -1);
        wr(1'b0, 8'h68);
        chk_out("R6 special mask on", 4);
        wr(1'b0, 8'h48);
        chk_out("R6 special mask off", -1);

        // R11 nested mode
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h10);
        pulse(8'h04);
        ack();
        pulse(8'h04);
        chk_out("R11 nested line 2", 2);

        // R4 setup paths, R3 base masking and clearing
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h2F);
        chk("R3 base and F8", vbase_o, 8'h28);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h33);
        rd(1'b1, v); chk("R4 link then normal", v, 8'h33);
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h08);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h77);
        rd(1'b1, v); chk("R4 link then mode word", v, 8'h77);
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h18);
        wr(1'b1, 8'h99);
        rd(1'b1, v); chk("R4 single no mode word", v, 8'h99);
        pulse(8'h01);
        wr(1'b0, 8'h13);
        rd(1'b1, v); chk("R3 mask cleared", v, 0);
        rd(1'b0, v); chk("R3 pending cleared", v, 0);

        finish_run();
    end

endmodule